// File: doc/BRIEF.md
# Divider-Compensated 5 µs Timebase

This block gives the flash programming sequencer a fixed real-time reference: a single-cycle pulse once every 5 µs. It keeps working when the system clock is divided down. Software programs a reload value while the system runs undivided. The value is the number of undivided clock cycles in 5 µs, minus one. For example, a 40 MHz clock needs a value of 199.

The system clock is divided by 2 raised to the power of a 3-bit divider code. The block keeps a working copy of the reload value that matches the current code, and a down-counter loads from that working copy. Any change of the divider code, or of the sub-clock select, reloads the counter at once, so the new period starts immediately.

When the low-frequency sub-clock drives the system, no scaling is applied. The block then raises a write-inhibit flag for the sequencer.

Top module: `flash_timebase`

## Requirements
- R1: After reset, `tick` is low, `wr_inhibit` is low and `rld_rdata` reads the reset reload value of 199.
- R2: A write (`rld_we` high at a rising edge) while `div_code` is 3'b000 stores `rld_wdata`. The new value is visible on `rld_rdata` after that edge.
- R3: A write while `div_code` is not 3'b000 is ignored, and `rld_rdata` keeps its previous value.
- R4: With `div_code` = 0 and `subclk_sel` low, `tick` rises once every reload+1 cycles.
- R5: With `div_code` = n and `subclk_sel` low, the working copy is ((reload+1) >> n) − 1, and `tick` rises once every (reload+1) >> n cycles.
- R6: When (reload+1) >> n is 0, the working copy floors at 0 and `tick` stays high on every cycle.
- R7: A change of `div_code` reloads the counter at once. The first `tick` after the change is high in the cycle after the (W+1)-th rising edge, counting from the edge that first samples the new code, where W is the new working copy.
- R8: With `subclk_sel` high, the working copy equals the reload value whatever the divider code, and `wr_inhibit` is high.
- R9: When the working copy is not 0, each `tick` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| div_code | input | 3 | Current system clock divider code (divide by 2^code) |
| subclk_sel | input | 1 | High when the sub-clock is the system clock |
| tick | output | 1 | 5 µs pulse |
| rld_rdata | output | 16 | Reload register readback |
| wr_inhibit | output | 1 | Flash write inhibit for the sequencer |

## Verification
The bench writes reload values both at divide-by-1 and at a non-zero code. A design that fails to gate writes would change the readback or the tick period.

It measures tick spacing at several divider codes, including code 7, where the shifted count underflows. A design missing the floor would wrap to a huge period instead of ticking every cycle.

It counts the exact cycle of the first tick after a divider change. A design that waited for the old count to expire would tick late.

It selects the sub-clock at a non-zero code. A design that still scaled would show a shortened period and no write inhibit.

// File: rtl/ftb_pkg.sv
// Package: shared widths and the reload scaling function for the timebase.
// Assumes divider codes map to divide-by-2^code.
package ftb_pkg;

    localparam int RLD_W = 16;
    localparam int DIV_W = 3;

    // Scale a divide-by-1 reload value to a divider code, flooring at zero.
    function automatic logic [RLD_W-1:0] scale_reload(
        input logic [RLD_W-1:0] rld,
        input logic [DIV_W-1:0] code,
        input logic             no_scale
    );
        logic [RLD_W:0] span;
        span = ({1'b0, rld} + 1'b1) >> code;
        if (no_scale)
            return rld;
        else if (span == '0)
            return '0;
        else
            return span[RLD_W-1:0] - 1'b1;
    endfunction

endpackage

// File: rtl/ftb_reload_reg.sv
// Module: software reload register.
// Accepts writes only while the divider code is zero; writes made at any
// other setting are dropped. Assumes a synchronous active-low reset.
module ftb_reload_reg #(
    parameter int RLD_W   = 16,
    parameter int DIV_W   = 3,
    parameter int RST_VAL = 199
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [RLD_W-1:0] wdata,
    input  logic [DIV_W-1:0] div_code,
    output logic [RLD_W-1:0] rld_q
);

    logic wr_ok;
    assign wr_ok = we && (div_code == '0);

    // Store the reload value on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rld_q <= RLD_W'(RST_VAL);
        else if (wr_ok)
            rld_q <= wdata;
    end

    // R2: a write at divide-by-1 lands on the next edge
    p_write_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && div_code == '0) |=> (rld_q == $past(wdata)));

    // R3: a write at any other divider code leaves the value untouched
    p_write_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code != '0) |=> $stable(rld_q));

endmodule

// File: rtl/ftb_scaler.sv
// Module: working-copy scaler.
// Derives the divider-adjusted count from the reload value and flags a reload
// whenever the divider code or sub-clock select changes. Assumes code n means
// divide by 2^n.
module ftb_scaler
    import ftb_pkg::*;
#(
    parameter int RLD_W_P = RLD_W,
    parameter int DIV_W_P = DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RLD_W_P-1:0] rld_q,
    input  logic [DIV_W_P-1:0] div_code,
    input  logic               subclk_sel,
    output logic [RLD_W_P-1:0] work_val,
    output logic               load_req
);

    logic [DIV_W_P-1:0] div_prev;
    logic               sub_prev;

    // Compute the working copy for the current clock setting.
    always_comb begin
        work_val = RLD_W_P'(scale_reload(RLD_W'(rld_q), DIV_W'(div_code), subclk_sel));
    end

    // Remember the last clock setting to spot changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_prev <= '0;
            sub_prev <= 1'b0;
        end else begin
            div_prev <= div_code;
            sub_prev <= subclk_sel;
        end
    end

    assign load_req = (div_code != div_prev) || (subclk_sel != sub_prev);

endmodule

// File: rtl/ftb_down_counter.sv
// Module: down-counter with tick.
// Loads the working copy on a clock-setting change or on reaching zero, and
// signals tick while at zero. Assumes the working copy is stable between loads.
module ftb_down_counter #(
    parameter int RLD_W   = 16,
    parameter int RST_VAL = 199
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RLD_W-1:0] work_val,
    input  logic             load_req,
    output logic             tick
);

    logic [RLD_W-1:0] cnt_q;

    // Count down, reloading on change or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RLD_W'(RST_VAL);
        else if (load_req || cnt_q == '0)
            cnt_q <= work_val;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);

    // R7: a clock-setting change loads the new working copy at once
    p_reload_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (cnt_q == $past(work_val)));

    // R4: without a reload the count steps down by one
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9: a tick lasts one cycle when the working copy is non-zero
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && work_val != '0) |=> !tick);

endmodule

// File: rtl/flash_timebase.sv
// Module: top of the divider-compensated 5 us timebase.
// Ties the reload register, scaler and counter together and raises the write
// inhibit while the sub-clock runs the system. Assumes synchronous inputs.
module flash_timebase
    import ftb_pkg::*;
#(
    parameter int RST_VAL = 199
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_we,
    input  logic [RLD_W-1:0] rld_wdata,
    input  logic [DIV_W-1:0] div_code,
    input  logic             subclk_sel,
    output logic             tick,
    output logic [RLD_W-1:0] rld_rdata,
    output logic             wr_inhibit
);

    logic [RLD_W-1:0] rld_q;
    logic [RLD_W-1:0] work_val;
    logic             load_req;

    ftb_reload_reg #(.RLD_W(RLD_W), .DIV_W(DIV_W), .RST_VAL(RST_VAL)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(rld_we), .wdata(rld_wdata),
        .div_code(div_code), .rld_q(rld_q)
    );

    ftb_scaler #(.RLD_W_P(RLD_W), .DIV_W_P(DIV_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .rld_q(rld_q), .div_code(div_code),
        .subclk_sel(subclk_sel), .work_val(work_val), .load_req(load_req)
    );

    ftb_down_counter #(.RLD_W(RLD_W), .RST_VAL(RST_VAL)) u_cnt (
        .clk(clk), .rst_n(rst_n), .work_val(work_val), .load_req(load_req),
        .tick(tick)
    );

    assign rld_rdata  = rld_q;
    assign wr_inhibit = subclk_sel;

    // R8: with the sub-clock selected the working copy ignores the divider
    p_no_scale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        subclk_sel |-> (work_val == rld_q));

endmodule

// File: tb/sim_flash_timebase.sv
module sim_flash_timebase;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rld_we;
    logic [15:0] rld_wdata;
    logic [2:0]  div_code;
    logic        subclk_sel;
    logic        tick;
    logic [15:0] rld_rdata;
    logic        wr_inhibit;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ntick = 0;
    int last_tick = 0;
    bit have_last = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    flash_timebase u0 (
        .clk(clk), .rst_n(rst_n), .rld_we(rld_we), .rld_wdata(rld_wdata),
        .div_code(div_code), .subclk_sel(subclk_sel), .tick(tick),
        .rld_rdata(rld_rdata), .wr_inhibit(wr_inhibit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: measure tick spacing and compare with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && tick) begin
            if (have_last && exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check((cyc - last_tick) == e, t, cyc - last_tick, e);
            end
            last_tick = cyc;
            have_last = 1;
            ntick++;
        end
    end

    task automatic settle();
        int t0;
        t0 = ntick;
        wait (ntick >= t0 + 3);
    endtask

    // Driver: push expected periods, then wait for the monitor to drain them.
    task automatic expect_period(input int per, input int n, input string req);
        settle();
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(per);
            tag_q.push_back(req);
        end
        wait (exp_q.size() == 0);
    endtask

    task automatic write_rld(input int val);
        @(negedge clk);
        rld_we = 1'b1;
        rld_wdata = 16'(val);
        @(negedge clk);
        rld_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rld_we = 1'b0; rld_wdata = '0; div_code = '0; subclk_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(tick == 1'b0, "R1", tick, 0);
        check(rld_rdata == 16'd199, "R1", rld_rdata, 199);
        check(wr_inhibit == 1'b0, "R1", wr_inhibit, 0);

        // R4 default period at divide-by-1
        expect_period(200, 2, "R4");

        // R2 write at code 0
        write_rld(49);
        check(rld_rdata == 16'd49, "R2", rld_rdata, 49);
        expect_period(50, 3, "R4");

        // R3 write at non-zero code ignored
        @(negedge clk);
        div_code = 3'd3;
        write_rld(77);
        check(rld_rdata == 16'd49, "R3", rld_rdata, 49);
        expect_period(6, 3, "R3");   // still scaled from 49: 50>>3 = 6

        // R7 immediate reload on change: 50>>2 = 12, W = 11
        @(negedge clk);
        div_code = 3'd2;
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 1 || k == 11) check(tick == 1'b0, "R7", tick, 0);
        end
        @(negedge clk);
        check(tick == 1'b1, "R7", tick, 1);

        // R5 periods at several codes
        expect_period(12, 3, "R5");
        @(negedge clk); div_code = 3'd1;
        expect_period(25, 3, "R5");
        @(negedge clk); div_code = 3'd5;
        expect_period(1, 3, "R5");   // 50>>5 = 1

        // R6 floor: 50>>7 = 0 -> tick every cycle
        @(negedge clk); div_code = 3'd7;
        expect_period(1, 4, "R6");
        repeat (2) @(negedge clk);
        check(tick == 1'b1, "R6", tick, 1);

        // R9 single-cycle tick with period 200
        @(negedge clk); div_code = 3'd0;
        write_rld(199);
        expect_period(200, 1, "R9");
        @(negedge clk);
        check(tick == 1'b0, "R9", tick, 0);

        // R8 sub-clock: no scaling at code 2, inhibit raised
        @(negedge clk); div_code = 3'd2;
        expect_period(50, 2, "R5");
        @(negedge clk); subclk_sel = 1'b1;
        @(negedge clk);
        check(wr_inhibit == 1'b1, "R8", wr_inhibit, 1);
        expect_period(200, 2, "R8");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule